// File: doc/BRIEF.md
# Bridge System Error Reporter

This block collects the error conditions seen by a two-bus bridge and turns them into an active-low system error pulse on the upstream bus. It listens to the downstream system error line and to one-cycle pulses from the transaction engines. It also watches three retry counters, one each for posted writes, delayed writes and delayed reads. Each counter gives up on a transfer once the retry limit is reached.

Every qualifying event drives the upstream line low for one clock, one cycle after the event. Sticky status bits record the cause and are cleared by writing ones. The master switch is the command-register enable. Six device events can each be masked by their own disable bit. Master timeout has no disable bit and is gated by its own bridge-control enable. Forwarding of the downstream line has a separate bridge-control enable.

Top module: `syserr_report`

## Requirements
- R1: After reset `priSerrN` is 1 and `sigSerrStat`, `rcvSerrStat` and all of `evtStatus` are 0.
- R2: While `cmdSerrEn` is 0, `priSerrN` stays 1 and no bit of `evtStatus` is set, whatever the other inputs do.
- R3: Whenever `priSerrN` is 0, `sigSerrStat` is 1 in the same cycle. It then stays 1 until it is cleared with `clrSigSerr`.
- R4: A low `secSerrN` sampled at a clock edge always sets `rcvSerrStat`. It drives `priSerrN` low for the next cycle only when both `fwdSerrEn` and `cmdSerrEn` are 1.
- R5: With `cmdSerrEn` = 1 and the matching disable bit 0, a pulse on any device event drives `priSerrN` low for exactly the following cycle and sets its `evtStatus` bit. The bits are: 0 target abort on posted write, 1 master abort on posted write, 2 parity error on posted write, 3 posted-write give-up, 4 delayed-write give-up, 5 delayed-read give-up, 6 master timeout.
- R6: `evtDisable[i]` = 1, for i in 0..5, stops event i from driving `priSerrN` and from setting `evtStatus[i]`.
- R7: Master timeout is qualified by `mtoSerrEn` alone and is not affected by `evtDisable`.
- R8: Retry counter k (0 posted write, 1 delayed write, 2 delayed read) raises its give-up event on the 2^RETRY_W-th `retryHit[k]` pulse. It raises it once only, until the counter is reset.
- R9: A `xferDone[k]` pulse resets counter k and re-arms its give-up event. Done wins over a retry in the same cycle.
- R10: Status bits are sticky and cleared by writing one. A clear and a new set in the same cycle leave the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdSerrEn | input | 1 | Command-register system error enable |
| fwdSerrEn | input | 1 | Bridge-control downstream forward enable |
| mtoSerrEn | input | 1 | Bridge-control master timeout enable |
| evtDisable | input | 6 | Per-event disable bits for events 0..5 |
| secSerrN | input | 1 | Downstream system error, active low |
| evtPwTgtAbort | input | 1 | Target abort on posted write, pulse |
| evtPwMstAbort | input | 1 | Master abort on posted write, pulse |
| evtPwParity | input | 1 | Target-bus parity error on posted write, pulse |
| evtMasterTimeout | input | 1 | Master timeout on delayed transaction, pulse |
| retryHit | input | 3 | Target retry received per transaction kind |
| xferDone | input | 3 | Transfer completed per transaction kind |
| statusClr | input | 7 | Write-one-to-clear for `evtStatus` |
| clrSigSerr | input | 1 | Write-one-to-clear for `sigSerrStat` |
| clrRcvSerr | input | 1 | Write-one-to-clear for `rcvSerrStat` |
| priSerrN | output | 1 | Upstream system error, active low, registered |
| sigSerrStat | output | 1 | Signaled system error status |
| rcvSerrStat | output | 1 | Received system error status |
| evtStatus | output | 7 | Per-event cause status |

## Verification
A wrong retry count is the slowest fault to show. It appears only as a give-up pulse that comes early, late or twice, so the bench counts through a whole short limit and the retries past it. A wrong qualification term shows one cycle after the event as a stray or missing low on `priSerrN`, together with a wrong `evtStatus` bit. A broken sticky or clear path shows on the status outputs in the cycle right after the write.

// File: rtl/syserr_pkg.sv
package syserr_pkg;
  localparam int NUM_EVT   = 7;  // device events with status bits
  localparam int NUM_MASK  = 6;  // events that have a disable bit
  localparam int NUM_RETRY = 3;  // posted write, delayed write, delayed read

  localparam int EV_PW_TABORT = 0;
  localparam int EV_PW_MABORT = 1;
  localparam int EV_PW_PARITY = 2;
  localparam int EV_PW_GIVEUP = 3;
  localparam int EV_DW_GIVEUP = 4;
  localparam int EV_DR_GIVEUP = 5;
  localparam int EV_MTO       = 6;

  typedef struct packed {
    logic [NUM_EVT-1:0] evtSet;
    logic               rcvSet;
    logic               fire;
  } serr_strobe_t;
endpackage

// File: rtl/syserr_retry_cnt.sv
module syserr_retry_cnt #(
  parameter int RETRY_W = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic retryHit,
  input  logic xferDone,
  output logic giveUp
);
  localparam logic [RETRY_W-1:0] CNT_MAX = {RETRY_W{1'b1}};

  logic [RETRY_W-1:0] count;
  logic               spent;

  assign giveUp = retryHit && !xferDone && (count == CNT_MAX) && !spent;

  always_ff @(posedge clk) begin
    if (!rstN || xferDone) begin
      count <= '0;
      spent <= 1'b0;
    end else if (retryHit) begin
      if (count == CNT_MAX) spent <= 1'b1;
      else                  count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/syserr_ctrl.sv
module syserr_ctrl
  import syserr_pkg::*;
#(
  parameter int RETRY_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdSerrEn,
  input  logic                 fwdSerrEn,
  input  logic                 mtoSerrEn,
  input  logic [NUM_MASK-1:0]  evtDisable,
  input  logic                 secSerrN,
  input  logic                 evtPwTgtAbort,
  input  logic                 evtPwMstAbort,
  input  logic                 evtPwParity,
  input  logic                 evtMasterTimeout,
  input  logic [NUM_RETRY-1:0] retryHit,
  input  logic [NUM_RETRY-1:0] xferDone,
  output serr_strobe_t         strobe
);
  logic [NUM_RETRY-1:0] giveUp;
  logic [NUM_EVT-1:0]   rawEvt;
  logic [NUM_EVT-1:0]   evtEnable;
  logic                 secFwd;

  for (genvar k = 0; k < NUM_RETRY; k++) begin : g_retry
    syserr_retry_cnt #(.RETRY_W(RETRY_W)) u_cnt (
      .clk      (clk),
      .rstN     (rstN),
      .retryHit (retryHit[k]),
      .xferDone (xferDone[k]),
      .giveUp   (giveUp[k])
    );
  end

  always_comb begin
    rawEvt                = '0;
    rawEvt[EV_PW_TABORT]  = evtPwTgtAbort;
    rawEvt[EV_PW_MABORT]  = evtPwMstAbort;
    rawEvt[EV_PW_PARITY]  = evtPwParity;
    rawEvt[EV_PW_GIVEUP]  = giveUp[0];
    rawEvt[EV_DW_GIVEUP]  = giveUp[1];
    rawEvt[EV_DR_GIVEUP]  = giveUp[2];
    rawEvt[EV_MTO]        = evtMasterTimeout;

    evtEnable             = {mtoSerrEn, ~evtDisable} & {NUM_EVT{cmdSerrEn}};
    secFwd                = !secSerrN && fwdSerrEn && cmdSerrEn;

    strobe.evtSet         = rawEvt & evtEnable;
    strobe.rcvSet         = !secSerrN;
    strobe.fire           = (|(rawEvt & evtEnable)) || secFwd;
  end
endmodule

// File: rtl/syserr_dpath.sv
module syserr_dpath
  import syserr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  serr_strobe_t       strobe,
  input  logic [NUM_EVT-1:0] statusClr,
  input  logic               clrSigSerr,
  input  logic               clrRcvSerr,
  output logic               priSerrN,
  output logic               sigSerrStat,
  output logic               rcvSerrStat,
  output logic [NUM_EVT-1:0] evtStatus
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      priSerrN    <= 1'b1;
      sigSerrStat <= 1'b0;
      rcvSerrStat <= 1'b0;
      evtStatus   <= '0;
    end else begin
      priSerrN    <= !strobe.fire;
      sigSerrStat <= (sigSerrStat && !clrSigSerr) || strobe.fire;
      rcvSerrStat <= (rcvSerrStat && !clrRcvSerr) || strobe.rcvSet;
      evtStatus   <= (evtStatus & ~statusClr) | strobe.evtSet;
    end
  end
endmodule

// File: rtl/syserr_report.sv
module syserr_report
  import syserr_pkg::*;
#(
  parameter int RETRY_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdSerrEn,
  input  logic                 fwdSerrEn,
  input  logic                 mtoSerrEn,
  input  logic [NUM_MASK-1:0]  evtDisable,
  input  logic                 secSerrN,
  input  logic                 evtPwTgtAbort,
  input  logic                 evtPwMstAbort,
  input  logic                 evtPwParity,
  input  logic                 evtMasterTimeout,
  input  logic [NUM_RETRY-1:0] retryHit,
  input  logic [NUM_RETRY-1:0] xferDone,
  input  logic [NUM_EVT-1:0]   statusClr,
  input  logic                 clrSigSerr,
  input  logic                 clrRcvSerr,
  output logic                 priSerrN,
  output logic                 sigSerrStat,
  output logic                 rcvSerrStat,
  output logic [NUM_EVT-1:0]   evtStatus
);
  serr_strobe_t strobe;

  syserr_ctrl #(.RETRY_W(RETRY_W)) u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .cmdSerrEn        (cmdSerrEn),
    .fwdSerrEn        (fwdSerrEn),
    .mtoSerrEn        (mtoSerrEn),
    .evtDisable       (evtDisable),
    .secSerrN         (secSerrN),
    .evtPwTgtAbort    (evtPwTgtAbort),
    .evtPwMstAbort    (evtPwMstAbort),
    .evtPwParity      (evtPwParity),
    .evtMasterTimeout (evtMasterTimeout),
    .retryHit         (retryHit),
    .xferDone         (xferDone),
    .strobe           (strobe)
  );

  syserr_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .statusClr   (statusClr),
    .clrSigSerr  (clrSigSerr),
    .clrRcvSerr  (clrRcvSerr),
    .priSerrN    (priSerrN),
    .sigSerrStat (sigSerrStat),
    .rcvSerrStat (rcvSerrStat),
    .evtStatus   (evtStatus)
  );
endmodule

// File: rtl/syserr_report_chk.sv
module syserr_report_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdSerrEn,
  input logic       mtoSerrEn,
  input logic [5:0] evtDisable,
  input logic       secSerrN,
  input logic       evtPwTgtAbort,
  input logic       evtMasterTimeout,
  input logic [6:0] statusClr,
  input logic       priSerrN,
  input logic       sigSerrStat,
  input logic       rcvSerrStat,
  input logic [6:0] evtStatus
);
  AST_NEEDS_CMD_EN: assert property (@(posedge clk) disable iff (!rstN)
    !priSerrN |-> $past(cmdSerrEn)); // R2
  AST_SIG_WITH_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !priSerrN |-> sigSerrStat); // R3
  AST_RCV_ALWAYS: assert property (@(posedge clk) disable iff (!rstN)
    !secSerrN |=> rcvSerrStat); // R4
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (evtPwTgtAbort && evtDisable[0]) |=> !$rose(evtStatus[0])); // R6
  AST_MTO_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (evtMasterTimeout && !mtoSerrEn) |=> !$rose(evtStatus[6])); // R7
  AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (evtStatus[0] && !statusClr[0]) |=> evtStatus[0]); // R10
endmodule

bind syserr_report syserr_report_chk u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .cmdSerrEn        (cmdSerrEn),
  .mtoSerrEn        (mtoSerrEn),
  .evtDisable       (evtDisable),
  .secSerrN         (secSerrN),
  .evtPwTgtAbort    (evtPwTgtAbort),
  .evtMasterTimeout (evtMasterTimeout),
  .statusClr        (statusClr),
  .priSerrN         (priSerrN),
  .sigSerrStat      (sigSerrStat),
  .rcvSerrStat      (rcvSerrStat),
  .evtStatus        (evtStatus)
);

// File: tb/sim_syserr_report.sv
`timescale 1ns/1ps
module sim_syserr_report;
  localparam int RW = 3;
  localparam int LIMIT = 1 << RW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdSerrEn = 0, fwdSerrEn = 0, mtoSerrEn = 0;
  logic [5:0] evtDisable = '0;
  logic secSerrN = 1'b1;
  logic evtPwTgtAbort = 0, evtPwMstAbort = 0, evtPwParity = 0, evtMasterTimeout = 0;
  logic [2:0] retryHit = '0, xferDone = '0;
  logic [6:0] statusClr = '0;
  logic clrSigSerr = 0, clrRcvSerr = 0;
  logic priSerrN, sigSerrStat, rcvSerrStat;
  logic [6:0] evtStatus;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  syserr_report #(.RETRY_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .cmdSerrEn(cmdSerrEn), .fwdSerrEn(fwdSerrEn),
    .mtoSerrEn(mtoSerrEn), .evtDisable(evtDisable), .secSerrN(secSerrN),
    .evtPwTgtAbort(evtPwTgtAbort), .evtPwMstAbort(evtPwMstAbort),
    .evtPwParity(evtPwParity), .evtMasterTimeout(evtMasterTimeout),
    .retryHit(retryHit), .xferDone(xferDone), .statusClr(statusClr),
    .clrSigSerr(clrSigSerr), .clrRcvSerr(clrRcvSerr), .priSerrN(priSerrN),
    .sigSerrStat(sigSerrStat), .rcvSerrStat(rcvSerrStat), .evtStatus(evtStatus)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    secSerrN = 1; evtPwTgtAbort = 0; evtPwMstAbort = 0; evtPwParity = 0;
    evtMasterTimeout = 0; retryHit = '0; xferDone = '0; statusClr = '0;
    clrSigSerr = 0; clrRcvSerr = 0;
  endtask

  // inputs already set at a negedge: pass one posedge, land on next negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearAll();
    statusClr = '1; clrSigSerr = 1; clrRcvSerr = 1;
    step();
    idleInputs();
    step();
  endtask

  task automatic setEvt(int idx, logic v);
    case (idx)
      0: evtPwTgtAbort = v;
      1: evtPwMstAbort = v;
      2: evtPwParity = v;
      default: evtMasterTimeout = v;
    endcase
  endtask

  task automatic tReset();
    check("R1 priSerrN", priSerrN, 1);
    check("R1 sigSerrStat", sigSerrStat, 0);
    check("R1 rcvSerrStat", rcvSerrStat, 0);
    check("R1 evtStatus", evtStatus, 0);
  endtask

  task automatic tDirectEvents();
    cmdSerrEn = 1; evtDisable = '0; mtoSerrEn = 1;
    for (int i = 0; i < 3; i++) begin
      clearAll();
      setEvt(i, 1);
      step();
      setEvt(i, 0);
      check("R5 out low", priSerrN, 0);
      check("R5 status bit", evtStatus, 32'(1 << i));
      check("R3 sig set", sigSerrStat, 1);
      step();
      check("R5 one clock", priSerrN, 1);
      check("R3 sig sticky", sigSerrStat, 1);
    end
  endtask

  task automatic tMask();
    clearAll();
    cmdSerrEn = 1; evtDisable = 6'b000111;
    for (int i = 0; i < 3; i++) begin
      setEvt(i, 1);
      step();
      setEvt(i, 0);
      check("R6 masked out", priSerrN, 1);
      check("R6 masked status", evtStatus, 0);
    end
    evtDisable = '0;
  endtask

  task automatic tCmdGate();
    clearAll();
    cmdSerrEn = 0; fwdSerrEn = 1; mtoSerrEn = 1;
    evtPwMstAbort = 1; evtMasterTimeout = 1; secSerrN = 0;
    step();
    idleInputs();
    check("R2 no out", priSerrN, 1);
    check("R2 no status", evtStatus, 0);
    check("R2 sig clear", sigSerrStat, 0);
    check("R4 rcv set anyway", rcvSerrStat, 1);
    cmdSerrEn = 1;
  endtask

  task automatic tForward();
    clearAll();
    fwdSerrEn = 0; secSerrN = 0;
    step();
    secSerrN = 1;
    check("R4 no forward", priSerrN, 1);
    check("R4 rcv set", rcvSerrStat, 1);
    check("R4 no evt status", evtStatus, 0);
    clearAll();
    fwdSerrEn = 1; secSerrN = 0;
    step();
    secSerrN = 1;
    check("R4 forwarded", priSerrN, 0);
    check("R4 rcv set en", rcvSerrStat, 1);
    step();
    check("R4 released", priSerrN, 1);
    fwdSerrEn = 0;
  endtask

  task automatic tMto();
    clearAll();
    mtoSerrEn = 0; evtDisable = '0; evtMasterTimeout = 1;
    step();
    evtMasterTimeout = 0;
    check("R7 gated off", priSerrN, 1);
    check("R7 no status", evtStatus, 0);
    mtoSerrEn = 1; evtDisable = '1; evtMasterTimeout = 1;
    step();
    evtMasterTimeout = 0;
    check("R7 ignores disables", priSerrN, 0);
    check("R7 status bit6", evtStatus, 32'h40);
    evtDisable = '0;
  endtask

  task automatic tRetry();
    for (int k = 0; k < 3; k++) begin
      clearAll();
      for (int n = 1; n < LIMIT; n++) begin
        retryHit[k] = 1;
        step();
        retryHit[k] = 0;
        if (priSerrN !== 1) check("R8 early giveup", priSerrN, 1);
      end
      retryHit[k] = 1;
      step();
      retryHit[k] = 0;
      check("R8 giveup at limit", priSerrN, 0);
      check("R8 giveup status", evtStatus, 32'(1 << (3 + k)));
      for (int n = 0; n < 3; n++) begin
        retryHit[k] = 1;
        step();
        retryHit[k] = 0;
        check("R8 fires once", priSerrN, 1);
      end
      xferDone[k] = 1;
      step();
      xferDone[k] = 0;
    end
  endtask

  task automatic tDoneReset();
    clearAll();
    for (int n = 0; n < 5; n++) begin
      retryHit[1] = 1; step(); retryHit[1] = 0;
    end
    xferDone[1] = 1; retryHit[1] = 1;
    step();
    xferDone[1] = 0; retryHit[1] = 0;
    for (int n = 1; n < LIMIT; n++) begin
      retryHit[1] = 1; step(); retryHit[1] = 0;
      if (priSerrN !== 1) check("R9 restart count", priSerrN, 1);
    end
    check("R9 no fire before limit", evtStatus, 0);
    retryHit[1] = 1; step(); retryHit[1] = 0;
    check("R9 fires after reset", priSerrN, 0);
    xferDone[1] = 1; step(); xferDone[1] = 0;
  endtask

  task automatic tW1c();
    clearAll();
    evtDisable = '0;
    evtPwTgtAbort = 1; step(); evtPwTgtAbort = 0;
    check("R10 set", evtStatus[0], 1);
    step();
    check("R10 sticky", evtStatus[0], 1);
    evtPwTgtAbort = 1; statusClr[0] = 1; step();
    evtPwTgtAbort = 0; statusClr[0] = 0;
    check("R10 set wins", evtStatus[0], 1);
    statusClr[0] = 1; step(); statusClr[0] = 0;
    check("R10 cleared", evtStatus[0], 0);
    check("R10 sig untouched", sigSerrStat, 1);
    clrSigSerr = 1; step(); clrSigSerr = 0;
    check("R10 sig cleared", sigSerrStat, 0);
  endtask

  initial begin
    idleInputs();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    step();
    tReset();
    tDirectEvents();
    tMask();
    tCmdGate();
    tForward();
    tMto();
    tRetry();
    tDoneReset();
    tW1c();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule